// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a four-beat memory burst. When the surrounding strobe logic accepts a new access, it raises a one-cycle load pulse. The sequencer then captures the whole incoming address. After that, it steps the two lowest bits through one of two beat orders, one step for each cycle in which the active-low advance input is low. When advance is high, the current address stays on the output and the burst is suspended. Read bursts and write bursts advance in the same way.

A static strap selects the beat order:

- Linear order counts the low bits up, modulo four, from the start value.
- Interleaved order XORs the start value with a beat index running 0, 1, 2, 3. This suits caches that fetch the critical word first.

The upper address bits are taken only at load time. The output is a single register holding the upper bits joined to the current beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a clock rise, `addr_o` becomes all zeros on that edge.
- R2: When `load_i` is high at a clock rise, `addr_o` equals `addr_i` after that edge, and the burst's beat index restarts at 0.
- R3: In a cycle with `load_i` high, the value of `adv_n_i` has no effect: the loaded address appears unchanged.
- R4: With `mode_i` = 0 (linear), each accepted advance sets the low two bits of `addr_o` to their previous value plus one, modulo four. For example, a start of 01 yields 01, 10, 11, 00.
- R5: With `mode_i` = 1 (interleaved), the low two bits after k advances equal the start value XOR (k mod 4). For example, a start of 01 yields 01, 00, 11, 10, and a start of 10 yields 10, 11, 00, 01.
- R6: When `load_i` is low and `adv_n_i` is high at a clock rise, `addr_o` keeps its value.
- R7: Advancing past the fourth beat repeats the sequence from the start value, so the fifth beat equals the first.
- R8: The bits of `addr_o` above bit 1 change only on a load. Between loads they ignore `addr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 1 | Order strap: 0 selects linear, 1 selects interleaved |
| load_i | input | 1 | Accepted address strobe; loads a new burst start |
| adv_n_i | input | 1 | Advance, active low |
| addr_i | input | 17 | Incoming address (ADDR_W) |
| addr_o | output | 17 | Registered burst address (ADDR_W) |

## Verification
The following are checked by assertions on every cycle:

- the full-address capture on a load, including when advance is asserted in that same cycle;
- the hold when neither load nor advance is active;
- the unchanged upper bits between loads;
- the plus-one step in linear order;
- the bit-0 toggle on every interleaved step;
- the restart of the beat index on a load.

Several behaviours show only in the bench's scenarios, which compare against an independent model:

- the complete interleaved sequence for different start values;
- the wrap that repeats the start value on the fifth beat;
- correct resumption after a suspended burst;
- the reset value.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BEAT_W_DEF = 2;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic [BEAT_W-1:0] start_i,
  output logic [BEAT_W-1:0] start_nxt_o,
  output logic [BEAT_W-1:0] idx_nxt_o
);
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] idx_q;

  always_comb begin
    start_nxt_o = start_q;
    idx_nxt_o   = idx_q;
    if (load_i) begin
      start_nxt_o = start_i;
      idx_nxt_o   = '0;
    end else if (!adv_n_i) begin
      idx_nxt_o = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      idx_q   <= '0;
    end else begin
      start_q <= start_nxt_o;
      idx_q   <= idx_nxt_o;
    end
  end

  // R2: a load restarts the beat index
  p_idx_restart_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (idx_q == '0));
  // R6: index frozen while suspended
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(idx_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] idx_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] lin_beat;
  logic [BEAT_W-1:0] ilv_beat;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_beat[b] = start_i[b] ^ idx_i[b];
    end
  endgenerate

  assign lin_beat = start_i + idx_i;

  always_comb begin
    unique case (order_i)
      ORDER_INTERLEAVE: beat_o = ilv_beat;
      default:          beat_o = lin_beat;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned BEAT_W = BEAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  logic [BEAT_W-1:0]  start_nxt;
  logic [BEAT_W-1:0]  idx_nxt;
  logic [BEAT_W-1:0]  beat_nxt;
  logic [UPPER_W-1:0] upper_q;
  logic [UPPER_W-1:0] upper_nxt;
  order_e             order;

  assign order = order_e'(mode_i);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .adv_n_i     (adv_n_i),
    .start_i     (addr_i[BEAT_W-1:0]),
    .start_nxt_o (start_nxt),
    .idx_nxt_o   (idx_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i (order),
    .start_i (start_nxt),
    .idx_i   (idx_nxt),
    .beat_o  (beat_nxt)
  );

  assign upper_nxt = load_i ? addr_i[ADDR_W-1:BEAT_W] : upper_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      addr_o  <= '0;
    end else begin
      upper_q <= upper_nxt;
      addr_o  <= {upper_nxt, beat_nxt};
    end
  end

  // R2/R3: load captures the full address whatever advance does
  p_load_capture_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(addr_i)));
  // R6: suspended burst holds the output
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(addr_o));
  // R8: upper bits move only on a load
  p_upper_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));
  // R4: linear step adds one modulo the beat count
  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && !mode_i && !$past(rst))
      |=> (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1));
  // R5: every interleaved step flips bit 0
  p_ilv_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && mode_i && !$past(rst))
      |=> (addr_o[0] != $past(addr_o[0])));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode_i;
  logic          load_i;
  logic          adv_n_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-3:0] m_up;
  logic [1:0]    m_start;
  logic [1:0]    m_idx;

  always #10 clk = ~clk;

  burst_addr_seq u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .load_i(load_i),
    .adv_n_i(adv_n_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  task automatic tick(input logic r, input logic md, input logic ld,
                      input logic an, input logic [AW-1:0] a, input string tag);
    logic [1:0] low;
    @(negedge clk);
    rst = r; mode_i = md; load_i = ld; adv_n_i = an; addr_i = a;
    if (r) begin
      m_up = '0; m_start = '0; m_idx = '0;
    end else if (ld) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_idx = '0;
    end else if (!an) begin
      m_idx = m_idx + 2'd1;
    end
    if (r) low = 2'b00;
    else if (md) low = m_start ^ m_idx;
    else low = m_start + m_idx;
    exp_q.push_back(r ? '0 : {m_up, low});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (addr_o !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, addr_o, e);
        end
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin : driver
    rst = 1'b1; mode_i = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; addr_i = '0;
    m_up = '0; m_start = '0; m_idx = '0;
    tick(1, 0, 0, 1, 17'h1FFFF, "R1");
    tick(1, 0, 1, 0, 17'h1FFFF, "R1");
    // linear: load with advance asserted (R3), then step
    tick(0, 0, 1, 0, 17'h12345, "R3");
    tick(0, 0, 0, 0, 17'h00000, "R4");
    tick(0, 0, 0, 0, 17'h00000, "R4");
    tick(0, 0, 0, 0, 17'h00000, "R4");
    tick(0, 0, 0, 0, 17'h00000, "R7");
    tick(0, 0, 0, 1, 17'h0AAAA, "R6");
    tick(0, 0, 0, 1, 17'h15555, "R8");
    tick(0, 0, 0, 0, 17'h1FFFF, "R4");
    // linear start 11 wraps to 00
    tick(0, 0, 1, 1, 17'h0F0F3, "R2");
    tick(0, 0, 0, 0, 17'h00000, "R4");
    // interleaved start 01
    tick(0, 1, 1, 1, 17'h15551, "R2");
    tick(0, 1, 0, 0, 17'h00000, "R5");
    tick(0, 1, 0, 0, 17'h00000, "R5");
    tick(0, 1, 0, 0, 17'h00000, "R5");
    tick(0, 1, 0, 0, 17'h00000, "R7");
    // interleaved start 10 with a suspend in the middle
    tick(0, 1, 1, 0, 17'h0C3C2, "R3");
    tick(0, 1, 0, 0, 17'h1FFFF, "R5");
    tick(0, 1, 0, 1, 17'h1FFFF, "R6");
    tick(0, 1, 0, 0, 17'h00001, "R5");
    tick(0, 1, 0, 0, 17'h00002, "R5");
    tick(0, 1, 0, 0, 17'h00003, "R7");
    tick(0, 1, 0, 1, 17'h10000, "R8");
    // reset mid-burst
    tick(1, 1, 0, 0, 17'h1FFFF, "R1");
    tick(0, 1, 0, 1, 17'h1FFFF, "R8");
    tick(0, 0, 0, 1, 17'h00000, "R6");
    @(negedge clk);
    load_i = 1'b0; adv_n_i = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule